// File: doc/BRIEF.md
# SDRAM Initialization Command Sequencer

This block brings a bank of up to eight SDRAM rows out of power-up. Given a `start` pulse, it runs a fixed sequence. It first waits for the supply and clocks to settle, then sends a no-operation command and lets the devices idle. Next it precharges every bank and runs a burst of auto-refresh (CBR) cycles. It then programs each device's mode register, returns the controller to normal operation, and finally turns on periodic refresh. All waits are counted in pulses of an external one-microsecond tick. A `done` flag reports the end of the sequence.

Each command is sent only to rows that hold memory. Row occupancy comes from a set of cumulative row boundary values, each in 8 MB units. A row is populated when its boundary is above the boundary of the row below it. The command leaves on a strobe together with the row index and a target byte address. That address is the row's base plus, for a mode-register load, the mode word already shifted left by three bits.

Outside the sequence, the same command generator can be used by hand. A 3-bit command-mode field is written first, and a trigger pulse then issues that command once to every populated row.

Top module: `sdinit_seq`

## Requirements
- R1: The command-mode field takes the codes 0 normal, 1 NOP, 2 precharge all, 3 mode register set, 4 CBR refresh. A write of 5, 6 or 7 leaves the stored field unchanged. When idle, a trigger pulse issues the stored command once to each populated row, and `cmdCode` carries the code.
- R2: The normal code (0) issues no command to any row. This holds for a manual trigger and for the normal step at the end of the sequence, which also leaves the stored field at 0.
- R3: Row i is populated only when its boundary is strictly greater than its start. Row 0 starts at 0 and every other row starts at the previous row's boundary. Its command address is the start times 2^23 (8 MB), with the low 23 bits zero except for a mode-register offset.
- R4: Within one command, populated rows are issued in ascending index order, one `cmdValid` cycle each, with the row index on `cmdRow`.
- R5: After `start`, the command stream is NOP, precharge all, eight CBR refreshes, then mode register set, each sent to every populated row. Nothing else is issued.
- R6: The waits are 200 ticks before the NOP and 200 ticks after it. They are 1 tick after the precharge, 1 tick after each CBR, and 2 ticks after the mode register set. Only ticks that arrive during a wait are counted.
- R7: The mode word has burst length code 010 in bits 2:0, burst type 1 in bit 3, and the CAS code in bits 6:4 (011 when `casLat3` is 1, else 010). Bits 11:7 are zero. The word is sent shifted left by 3, giving an address offset of 0x1D0 for CAS 3 and 0x150 for CAS 2.
- R8: `refreshEn` is cleared by reset and by `start`, and it stays low for the whole sequence. `refreshEn` and `done` rise together in the cycle after the normal step and then stay high.
- R9: A `start` or trigger pulse that arrives while the sequence is running has no effect on the command stream.
- R10: If `start` and the trigger arrive in the same idle cycle, `start` wins and the manual command is dropped.
- R11: After reset, no command is issued, `refreshEn` and `done` are low, and the stored field holds the normal code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Write strobe for the command-mode field |
| cfgMode | input | 3 | Command-mode value to store |
| issueReq | input | 1 | Manual trigger: issue the stored command to populated rows |
| start | input | 1 | Begin the power-up sequence |
| usTick | input | 1 | One-cycle pulse every microsecond |
| casLat3 | input | 1 | 1 selects CAS latency 3, 0 selects CAS latency 2 |
| rowBound | input | ROWS*BOUND_W | Cumulative row boundaries in 8 MB units, row 0 in the low byte |
| cmdValid | output | 1 | A command is issued this cycle |
| cmdCode | output | 3 | Code of the issued command |
| cmdRow | output | ROW_W | Target row index |
| cmdAddr | output | ADDR_W | Target byte address |
| refreshEn | output | 1 | Periodic refresh enabled |
| done | output | 1 | Power-up sequence complete |

## Verification
Two functions can coincide in one cycle. The first is an idle trigger together with a `start`. The second is a stray `start` or trigger in the middle of a running sequence. Both arbitrate for the same row scanner and mode field. The bench asserts `start` and `issueReq` in the same idle cycle, and later pulses both halfway through a run. In each case it compares every issued command against a stream built only from the row boundaries. A dropped manual command, a restart or a duplicated scan would show up as an extra or misplaced entry, or as a wrong tick total at `done`.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

  localparam logic [2:0] CMD_NORMAL    = 3'd0;
  localparam logic [2:0] CMD_NOP       = 3'd1;
  localparam logic [2:0] CMD_PRECHARGE = 3'd2;
  localparam logic [2:0] CMD_MODESET   = 3'd3;
  localparam logic [2:0] CMD_REFRESH   = 3'd4;
  localparam logic [2:0] CMD_LAST_OK   = 3'd4;

  localparam logic [2:0] CAS_CODE_2 = 3'b010;
  localparam logic [2:0] CAS_CODE_3 = 3'b011;

  localparam int DLY_W = 16;

  typedef enum logic [3:0] {
    PH_IDLE, PH_MANUAL, PH_PWRWAIT, PH_NOP, PH_NOPWAIT, PH_PRE, PH_PREWAIT,
    PH_CBR, PH_CBRWAIT, PH_MRS, PH_MRSWAIT, PH_NORMAL
  } phase_t;

  // control to datapath strobes
  typedef struct packed {
    logic             clrDelay;
    logic             countEn;
    logic [DLY_W-1:0] delayTarget;
    logic             scanStart;
    logic             scanEn;
    logic             loadMode;
    logic [2:0]       modeVal;
    logic             setRefresh;
    logic             clrRefresh;
  } strobe_t;

  // 12-bit mode word: bl[2:0], bt[3], cas[6:4], op[8:7]=0, wb[9]=0, [11:10]=0
  function automatic logic [11:0] formModeWord(input logic [2:0] casCode,
                                               input logic [2:0] blCode,
                                               input logic       burstType);
    return {2'b00, 1'b0, 2'b00, casCode, burstType, blCode};
  endfunction

endpackage

// File: rtl/sdinit_ctrl.sv
module sdinit_ctrl
  import sdinit_pkg::*;
#(
  parameter int PWR_US    = 200,
  parameter int NOP_US    = 200,
  parameter int PRE_US    = 1,
  parameter int CBR_US    = 1,
  parameter int MRS_US    = 2,
  parameter int CBR_COUNT = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    issueReq,
  input  logic    modeIsNormal,
  input  logic    delayDone,
  input  logic    scanLast,
  output strobe_t stb,
  output logic    seqActive
);

  localparam int CBR_W = $clog2(CBR_COUNT + 1);

  phase_t           phase, nextPhase;
  logic [CBR_W-1:0] cbrCnt, cbrNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      cbrCnt <= '0;
    end else begin
      phase  <= nextPhase;
      cbrCnt <= cbrNext;
    end
  end

  always_comb begin
    stb       = '0;
    nextPhase = phase;
    cbrNext   = cbrCnt;
    case (phase)
      PH_IDLE: begin
        if (start) begin
          nextPhase      = PH_PWRWAIT;
          stb.clrDelay   = 1'b1;
          stb.clrRefresh = 1'b1;
          cbrNext        = '0;
        end else if (issueReq && !modeIsNormal) begin
          nextPhase     = PH_MANUAL;
          stb.scanStart = 1'b1;
        end
      end
      PH_MANUAL: begin
        stb.scanEn = 1'b1;
        if (scanLast) nextPhase = PH_IDLE;
      end
      PH_PWRWAIT: begin
        stb.countEn     = 1'b1;
        stb.delayTarget = DLY_W'(PWR_US);
        if (delayDone) begin
          nextPhase     = PH_NOP;
          stb.loadMode  = 1'b1;
          stb.modeVal   = CMD_NOP;
          stb.scanStart = 1'b1;
        end
      end
      PH_NOP: begin
        stb.scanEn = 1'b1;
        if (scanLast) begin
          nextPhase    = PH_NOPWAIT;
          stb.clrDelay = 1'b1;
        end
      end
      PH_NOPWAIT: begin
        stb.countEn     = 1'b1;
        stb.delayTarget = DLY_W'(NOP_US);
        if (delayDone) begin
          nextPhase     = PH_PRE;
          stb.loadMode  = 1'b1;
          stb.modeVal   = CMD_PRECHARGE;
          stb.scanStart = 1'b1;
        end
      end
      PH_PRE: begin
        stb.scanEn = 1'b1;
        if (scanLast) begin
          nextPhase    = PH_PREWAIT;
          stb.clrDelay = 1'b1;
        end
      end
      PH_PREWAIT: begin
        stb.countEn     = 1'b1;
        stb.delayTarget = DLY_W'(PRE_US);
        if (delayDone) begin
          nextPhase     = PH_CBR;
          stb.loadMode  = 1'b1;
          stb.modeVal   = CMD_REFRESH;
          stb.scanStart = 1'b1;
        end
      end
      PH_CBR: begin
        stb.scanEn = 1'b1;
        if (scanLast) begin
          nextPhase    = PH_CBRWAIT;
          stb.clrDelay = 1'b1;
        end
      end
      PH_CBRWAIT: begin
        stb.countEn     = 1'b1;
        stb.delayTarget = DLY_W'(CBR_US);
        if (delayDone) begin
          stb.scanStart = 1'b1;
          if (cbrCnt == CBR_W'(CBR_COUNT - 1)) begin
            nextPhase    = PH_MRS;
            stb.loadMode = 1'b1;
            stb.modeVal  = CMD_MODESET;
            cbrNext      = '0;
          end else begin
            nextPhase = PH_CBR;
            cbrNext   = cbrCnt + 1'b1;
          end
        end
      end
      PH_MRS: begin
        stb.scanEn = 1'b1;
        if (scanLast) begin
          nextPhase    = PH_MRSWAIT;
          stb.clrDelay = 1'b1;
        end
      end
      PH_MRSWAIT: begin
        stb.countEn     = 1'b1;
        stb.delayTarget = DLY_W'(MRS_US);
        if (delayDone) begin
          nextPhase    = PH_NORMAL;
          stb.loadMode = 1'b1;
          stb.modeVal  = CMD_NORMAL;
        end
      end
      PH_NORMAL: begin
        stb.setRefresh = 1'b1;
        nextPhase      = PH_IDLE;
      end
      default: nextPhase = PH_IDLE;
    endcase
  end

  assign seqActive = (phase != PH_IDLE) && (phase != PH_MANUAL);

endmodule

// File: rtl/sdinit_dp.sv
module sdinit_dp
  import sdinit_pkg::*;
#(
  parameter int         ROWS       = 8,
  parameter int         ROW_W      = 3,
  parameter int         BOUND_W    = 8,
  parameter int         ADDR_W     = 32,
  parameter int         ROW_SHIFT  = 23,
  parameter logic [2:0] BL_CODE    = 3'b010,
  parameter logic       BURST_TYPE = 1'b1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 stb,
  input  logic                    cfgWrEn,
  input  logic [2:0]              cfgMode,
  input  logic                    usTick,
  input  logic                    casLat3,
  input  logic [ROWS*BOUND_W-1:0] rowBound,
  output logic                    modeIsNormal,
  output logic                    delayDone,
  output logic                    scanLast,
  output logic                    cmdValid,
  output logic [2:0]              cmdCode,
  output logic [ROW_W-1:0]        cmdRow,
  output logic [ADDR_W-1:0]       cmdAddr,
  output logic                    refreshEn,
  output logic                    done
);

  localparam int OFFS_W = 15;

  logic [2:0]       modeField;
  logic [ROW_W-1:0] rowIdx;
  logic [DLY_W-1:0] delayCnt;
  logic             refreshQ, doneQ;

  logic [BOUND_W-1:0] rowStart [ROWS];
  logic [ROWS-1:0]    rowOcc;

  // per-row start and occupancy
  for (genvar gi = 0; gi < ROWS; gi++) begin : g_row
    logic [BOUND_W-1:0] rowEnd;
    assign rowEnd = rowBound[gi*BOUND_W +: BOUND_W];
    if (gi == 0) begin : g_first
      assign rowStart[gi] = '0;
    end else begin : g_next
      assign rowStart[gi] = rowBound[(gi-1)*BOUND_W +: BOUND_W];
    end
    assign rowOcc[gi] = rowEnd > rowStart[gi];
  end

  // command-mode field: sequence load wins, reserved codes dropped
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeField <= CMD_NORMAL;
    end else if (stb.loadMode) begin
      modeField <= stb.modeVal;
    end else if (cfgWrEn && (cfgMode <= CMD_LAST_OK)) begin
      modeField <= cfgMode;
    end
  end

  // row scanner
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowIdx <= '0;
    end else if (stb.scanStart) begin
      rowIdx <= '0;
    end else if (stb.scanEn) begin
      rowIdx <= rowIdx + 1'b1;
    end
  end

  // microsecond tick counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      delayCnt <= '0;
    end else if (stb.clrDelay) begin
      delayCnt <= '0;
    end else if (stb.countEn && usTick) begin
      delayCnt <= delayCnt + 1'b1;
    end
  end

  // refresh enable and completion
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refreshQ <= 1'b0;
      doneQ    <= 1'b0;
    end else if (stb.clrRefresh) begin
      refreshQ <= 1'b0;
      doneQ    <= 1'b0;
    end else if (stb.setRefresh) begin
      refreshQ <= 1'b1;
      doneQ    <= 1'b1;
    end
  end

  // mode word and address formation
  logic [11:0]       modeWord;
  logic [OFFS_W-1:0] modeOffset;
  logic [ADDR_W-1:0] baseAddr;

  assign modeWord   = formModeWord(casLat3 ? CAS_CODE_3 : CAS_CODE_2, BL_CODE, BURST_TYPE);
  assign modeOffset = {modeWord, 3'b000};
  assign baseAddr   = ADDR_W'(rowStart[rowIdx]) << ROW_SHIFT;

  assign modeIsNormal = (modeField == CMD_NORMAL);
  assign delayDone    = (delayCnt >= stb.delayTarget);
  assign scanLast     = (rowIdx == ROW_W'(ROWS - 1));
  assign cmdValid     = stb.scanEn && rowOcc[rowIdx] && !modeIsNormal;
  assign cmdCode      = modeField;
  assign cmdRow       = rowIdx;
  assign cmdAddr      = baseAddr | ((modeField == CMD_MODESET) ? ADDR_W'(modeOffset) : '0);
  assign refreshEn    = refreshQ;
  assign done         = doneQ;

endmodule

// File: rtl/sdinit_seq.sv
module sdinit_seq
  import sdinit_pkg::*;
#(
  parameter int         ROWS       = 8,
  parameter int         ROW_W      = $clog2(ROWS),
  parameter int         BOUND_W    = 8,
  parameter int         ADDR_W     = 32,
  parameter int         ROW_SHIFT  = 23,
  parameter int         PWR_US     = 200,
  parameter int         NOP_US     = 200,
  parameter int         PRE_US     = 1,
  parameter int         CBR_US     = 1,
  parameter int         MRS_US     = 2,
  parameter int         CBR_COUNT  = 8,
  parameter logic [2:0] BL_CODE    = 3'b010,
  parameter logic       BURST_TYPE = 1'b1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgWrEn,
  input  logic [2:0]              cfgMode,
  input  logic                    issueReq,
  input  logic                    start,
  input  logic                    usTick,
  input  logic                    casLat3,
  input  logic [ROWS*BOUND_W-1:0] rowBound,
  output logic                    cmdValid,
  output logic [2:0]              cmdCode,
  output logic [ROW_W-1:0]        cmdRow,
  output logic [ADDR_W-1:0]       cmdAddr,
  output logic                    refreshEn,
  output logic                    done
);

  strobe_t stb;
  logic    modeIsNormal, delayDone, scanLast, seqActive;

  sdinit_ctrl #(
    .PWR_US(PWR_US), .NOP_US(NOP_US), .PRE_US(PRE_US),
    .CBR_US(CBR_US), .MRS_US(MRS_US), .CBR_COUNT(CBR_COUNT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .issueReq(issueReq),
    .modeIsNormal(modeIsNormal), .delayDone(delayDone), .scanLast(scanLast),
    .stb(stb), .seqActive(seqActive)
  );

  sdinit_dp #(
    .ROWS(ROWS), .ROW_W(ROW_W), .BOUND_W(BOUND_W), .ADDR_W(ADDR_W),
    .ROW_SHIFT(ROW_SHIFT), .BL_CODE(BL_CODE), .BURST_TYPE(BURST_TYPE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgWrEn(cfgWrEn), .cfgMode(cfgMode),
    .usTick(usTick), .casLat3(casLat3), .rowBound(rowBound),
    .modeIsNormal(modeIsNormal), .delayDone(delayDone), .scanLast(scanLast),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdRow(cmdRow), .cmdAddr(cmdAddr),
    .refreshEn(refreshEn), .done(done)
  );

endmodule

// File: rtl/sdinit_chk.sv
module sdinit_chk #(
  parameter int ROW_W     = 3,
  parameter int ADDR_W    = 32,
  parameter int ROW_SHIFT = 23
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [2:0]        cmdCode,
  input logic [ROW_W-1:0]  cmdRow,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic              casLat3,
  input logic              refreshEn,
  input logic              done,
  input logic              seqActive
);

  assert_cmd_code_legal_R1: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdCode >= 3'd1 && cmdCode <= 3'd4));

  assert_no_normal_cmd_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> cmdCode != 3'd0);

  assert_addr_align_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode != 3'd3) |-> cmdAddr[ROW_SHIFT-1:0] == '0);

  assert_row_ascend_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && $past(cmdValid)) |-> cmdRow == $past(cmdRow) + ROW_W'(1));

  assert_mrs_cas_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == 3'd3) |->
      (cmdAddr[9:7] == (casLat3 ? 3'd3 : 3'd2)) && (cmdAddr[14:10] == 5'd0));

  assert_refresh_low_in_seq_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && seqActive) |-> !refreshEn);

  assert_done_with_refresh_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> refreshEn);

  assert_refresh_rise_at_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refreshEn) |-> $past(seqActive));

endmodule

bind sdinit_seq sdinit_chk #(
  .ROW_W(ROW_W), .ADDR_W(ADDR_W), .ROW_SHIFT(ROW_SHIFT)
) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
  .cmdRow(cmdRow), .cmdAddr(cmdAddr), .casLat3(casLat3),
  .refreshEn(refreshEn), .done(done), .seqActive(seqActive)
);

// File: tb/sim_sdinit_seq.sv
module sim_sdinit_seq;

  localparam int ROWS = 8;
  localparam int BW   = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [2:0] cfgMode = 3'd0;
  logic issueReq = 1'b0;
  logic start = 1'b0;
  logic usTick = 1'b0;
  logic casLat3 = 1'b1;
  logic [ROWS*BW-1:0] rowBound = '0;
  logic cmdValid;
  logic [2:0] cmdCode;
  logic [2:0] cmdRow;
  logic [31:0] cmdAddr;
  logic refreshEn, done;

  always #5 clk = ~clk;

  sdinit_seq u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgMode(cfgMode),
    .issueReq(issueReq), .start(start), .usTick(usTick), .casLat3(casLat3),
    .rowBound(rowBound), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdRow(cmdRow), .cmdAddr(cmdAddr), .refreshEn(refreshEn), .done(done)
  );

  int checks = 0;
  int fails = 0;
  int bnd [ROWS];
  bit cas3 = 1'b1;
  int expCode [128];
  int expRow [128];
  logic [31:0] expAddr [128];
  int expN = 0;
  int expIdx = 0;
  bit inSeq = 1'b0;
  int tickTotal = 0;
  int ticksAtFirst = 0;
  bit firstSeen = 1'b0;
  int tickPh = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int rowStartOf(input int i);
    return (i == 0) ? 0 : bnd[i-1];
  endfunction

  function automatic bit rowUsed(input int i);
    return bnd[i] > rowStartOf(i);
  endfunction

  function automatic logic [31:0] addrOf(input int i, input int code);
    logic [31:0] a;
    a = 32'(rowStartOf(i)) << 23;
    if (code == 3) a = a | (cas3 ? 32'h1D0 : 32'h150);
    return a;
  endfunction

  task automatic addCmd(input int code);
    for (int i = 0; i < ROWS; i++) begin
      if (rowUsed(i)) begin
        expCode[expN] = code;
        expRow[expN]  = i;
        expAddr[expN] = addrOf(i, code);
        expN++;
      end
    end
  endtask

  task automatic applyBounds();
    for (int i = 0; i < ROWS; i++) rowBound[i*BW +: BW] = 8'(bnd[i]);
    casLat3 = cas3;
  endtask

  task automatic randomBounds();
    int b;
    b = 0;
    for (int i = 0; i < ROWS; i++) begin
      if ($urandom % 4 != 0) b = b + int'($urandom % 6);
      bnd[i] = b;
    end
  endtask

  // microsecond tick: one pulse every 10 cycles
  always @(posedge clk) begin
    #1;
    tickPh = (tickPh == 9) ? 0 : tickPh + 1;
    usTick = (tickPh == 0);
  end

  // output monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rstN) begin
      if (usTick) tickTotal++;
      if (refreshEn != done) check(1'b0, "R8", "refreshEn vs done", refreshEn, done);
      if (cmdValid) begin
        if (!firstSeen) begin
          firstSeen = 1'b1;
          ticksAtFirst = tickTotal;
        end
        if (inSeq && refreshEn) check(1'b0, "R8", "refresh high during sequence", 1, 0);
        if (expIdx < expN) begin
          check(cmdCode == 3'(expCode[expIdx]), "R1/R5", "command code", cmdCode, expCode[expIdx]);
          check(cmdRow == 3'(expRow[expIdx]), "R4", "row index", cmdRow, expRow[expIdx]);
          check(cmdAddr == expAddr[expIdx], "R3/R7", "address", cmdAddr, expAddr[expIdx]);
        end else begin
          check(1'b0, "R2/R9", "unexpected command", cmdCode, 0);
        end
        expIdx++;
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic manualIssue(input int wrCode, input int expectCode, input string req);
    @(posedge clk); #2;
    cfgWrEn = 1'b1; cfgMode = 3'(wrCode);
    @(posedge clk); #2;
    cfgWrEn = 1'b0;
    expN = 0; expIdx = 0;
    if (expectCode != 0) addCmd(expectCode);
    issueReq = 1'b1;
    @(posedge clk); #2;
    issueReq = 1'b0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(expIdx == expN, req, "manual command count", expIdx, expN);
  endtask

  task automatic runSeq(input bit collide, input bit midStart);
    int waitCnt;
    expN = 0; expIdx = 0;
    addCmd(1); addCmd(2);
    repeat (8) addCmd(4);
    addCmd(3);
    @(posedge clk); #2;
    start = 1'b1; issueReq = collide;
    tickTotal = 0; firstSeen = 1'b0; inSeq = 1'b1;
    @(posedge clk); #2;
    start = 1'b0; issueReq = 1'b0;
    @(negedge clk);
    check(!refreshEn && !done, "R8", "refresh cleared at start", refreshEn, 0);
    if (midStart) begin
      repeat (1500) @(posedge clk);
      #2; start = 1'b1; issueReq = 1'b1;
      @(posedge clk); #2;
      start = 1'b0; issueReq = 1'b0;
    end
    waitCnt = 0;
    while (!done && waitCnt < 20000) begin
      @(negedge clk);
      waitCnt++;
    end
    inSeq = 1'b0;
    check(done && refreshEn, "R8", "done and refresh at end", {done, refreshEn}, 3);
    check(expIdx == expN, collide ? "R10" : (midStart ? "R9" : "R5"),
          "sequence command count", expIdx, expN);
    if (expN > 0)
      check(ticksAtFirst >= 200 && ticksAtFirst <= 202, "R6", "ticks before NOP",
            ticksAtFirst, 200);
    check(tickTotal >= 411 && tickTotal <= 425, "R6", "total ticks", tickTotal, 411);
    repeat (5) @(posedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < ROWS; i++) bnd[i] = 0;
    repeat (4) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    check(!cmdValid, "R11", "no command after reset", cmdValid, 0);
    check(!refreshEn && !done, "R11", "refresh/done low after reset", {refreshEn, done}, 0);

    // reset field is normal: trigger gives nothing
    randomBounds(); cas3 = 1'b1; applyBounds();
    expN = 0; expIdx = 0;
    @(posedge clk); #2 issueReq = 1'b1;
    @(posedge clk); #2 issueReq = 1'b0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(expIdx == 0, "R11", "reset mode is normal", expIdx, 0);

    // manual commands and reserved codes
    manualIssue(2, 2, "R1");
    manualIssue(5, 2, "R1");
    manualIssue(3, 3, "R7");
    manualIssue(0, 0, "R2");
    manualIssue(7, 0, "R1");

    // full sequence, CAS 3
    runSeq(1'b0, 1'b0);
    // after the sequence the field is normal
    expN = 0; expIdx = 0;
    @(posedge clk); #2 issueReq = 1'b1;
    @(posedge clk); #2 issueReq = 1'b0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(expIdx == 0, "R2", "field normal after sequence", expIdx, 0);
    check(refreshEn, "R8", "refresh stays on", refreshEn, 1);

    // non-monotonic bounds, CAS 2, stray start/trigger mid-run
    bnd[0] = 2; bnd[1] = 2; bnd[2] = 5; bnd[3] = 3;
    bnd[4] = 9; bnd[5] = 9; bnd[6] = 12; bnd[7] = 20;
    cas3 = 1'b0; applyBounds();
    runSeq(1'b0, 1'b1);

    // start and trigger together
    randomBounds(); cas3 = 1'b1; applyBounds();
    cfgWrEn = 1'b1; cfgMode = 3'd2;
    @(posedge clk); #2 cfgWrEn = 1'b0;
    runSeq(1'b1, 1'b0);

    // all rows empty
    for (int i = 0; i < ROWS; i++) bnd[i] = 0;
    applyBounds();
    runSeq(1'b0, 1'b0);

    // random manual commands
    for (int k = 0; k < 4; k++) begin
      int c;
      randomBounds(); cas3 = 1'($urandom % 2); applyBounds();
      c = 1 + int'($urandom % 4);
      manualIssue(c, c, "R1");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule